// File: doc/BRIEF.md
# Vectored Interrupt Request Arbiter

This block collects interrupt requests from a set of devices and folds them into one request line toward the processor. Each device raises its request bit when it wants service. A per-device enable masks it, and a global enable gates the shared line. When several enabled devices request at once, the device with the lowest index wins.

The winner's index is presented as a short vector code. The code also forms the low field of a service-routine address, whose upper bits come from a fixed base. When the processor raises its acknowledge, the block freezes the code. It then sends a single-cycle acknowledge pulse to the granted device, which clears its request on that pulse. The code stays frozen until the processor drops its acknowledge. Software typically clears the global enable at the start of the service routine and sets it again at the end.

Top module: `irq_vector_arb`

## Requirements
- R1: `irq_line` is high in the cycle after a clock edge at which `glb_en` was 1 and at least one bit of `dev_req & dev_en` was 1. Otherwise it is low.
- R2: When no grant is held, `vec_code` shows the lowest index i with `dev_req[i] & dev_en[i]` set, one cycle after that edge, and `vec_valid` is 1.
- R3: When `glb_en` is 0 at an edge and no grant is held, `irq_line` and `vec_valid` are 0 in the next cycle and `vec_code` is 0.
- R4: `isr_addr` equals the upper ADDR_W-CODE_W bits of VEC_BASE, with `vec_code` in bits CODE_W-1:0.
- R5: A rising `cpu_ack` seen while `vec_valid` is 1 produces a one-cycle pulse on `dev_ack`, in the next cycle, only at bit `vec_code`. A rising `cpu_ack` seen while `vec_valid` is 0 produces no pulse.
- R6: From a grant until `cpu_ack` is sampled low, `vec_code` and `vec_valid` stay fixed, even when a higher-priority request arrives.
- R7: With no enabled request pending and no grant held, `irq_line`, `vec_valid` and `vec_code` are all 0.
- R8: A request whose `dev_en` bit is 0 has no effect on `irq_line`, `vec_code` or `dev_ack`.
- R9: After synchronous reset, all outputs are 0 and `isr_addr` equals the base with a zero low field.
- R10: One cycle after `cpu_ack` is sampled low, `vec_code` again follows the current winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_DEV | Per-device request bits |
| dev_en | input | NUM_DEV | Per-device enable mask |
| glb_en | input | 1 | Global interrupt enable |
| cpu_ack | input | 1 | Processor acknowledge level |
| irq_line | output | 1 | Shared request line |
| vec_code | output | CODE_W | Vector code of the selected device |
| vec_valid | output | 1 | Vector code is meaningful |
| isr_addr | output | ADDR_W | Base with the vector code in the low field |
| dev_ack | output | NUM_DEV | One-cycle acknowledge to the granted device |

## Verification
Several properties are checked on every cycle. The acknowledge vector must be at most one-hot and last only one cycle, and it must point at the presented code. The code must hold steady while a grant persists. The shared line must fall when global enable is off, and an idle input must yield an idle output. Only the bench's scenarios can show that the right device wins among mixed requests and that masked devices are ignored. They also show that the address field is formed correctly and that the code resumes tracking after release. The bench does this by running directed cases and a long random sequence against a cycle model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [0:0] {
    GRANT_FREE = 1'b0,
    GRANT_HELD = 1'b1
  } grant_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_DEV = 8,
  parameter int CODE_W  = 4
) (
  input  logic [NUM_DEV-1:0] pend,
  output logic               any,
  output logic [CODE_W-1:0]  win
);
  // lowest index wins: scan downward so the last hit is the smallest index
  always_comb begin
    win = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (pend[i]) win = CODE_W'(i);
    end
  end

  assign any = |pend;
endmodule

// File: rtl/irq_addr_form.sv
module irq_addr_form #(
  parameter int                ADDR_W   = 16,
  parameter int                CODE_W   = 4,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0C30
) (
  input  logic [CODE_W-1:0] code,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - CODE_W;

  assign addr = {VEC_BASE[ADDR_W-1:CODE_W], code};

  initial begin
    AST_ADDR_FIELDS: assert (HI_W > 0); // R4
  end
endmodule

// File: rtl/irq_grant_hold.sv
module irq_grant_hold
  import irq_arb_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int CODE_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic               any,
  input  logic [CODE_W-1:0]  win,
  input  logic               cpu_ack,
  output logic               irq_line,
  output logic               vec_valid,
  output logic [CODE_W-1:0]  vec_code,
  output logic [NUM_DEV-1:0] dev_ack
);
  grant_state_e      st_q, st_n;
  logic              ack_d_q;
  logic              ack_rise, take;
  logic [CODE_W-1:0] code_n;
  logic              valid_n;
  logic [NUM_DEV-1:0] ack_n;

  assign ack_rise = cpu_ack & ~ack_d_q;
  assign take     = ack_rise & vec_valid;

  always_comb begin
    st_n = (cpu_ack && (st_q == GRANT_HELD || take)) ? GRANT_HELD : GRANT_FREE;
    if (st_n == GRANT_HELD) begin
      code_n  = vec_code;
      valid_n = 1'b1;
    end else if (glb_en && any) begin
      code_n  = win;
      valid_n = 1'b1;
    end else begin
      code_n  = '0;
      valid_n = 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_ack
      assign ack_n[g] = take && (vec_code == CODE_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= GRANT_FREE;
      ack_d_q   <= 1'b0;
      irq_line  <= 1'b0;
      vec_valid <= 1'b0;
      vec_code  <= '0;
      dev_ack   <= '0;
    end else begin
      st_q      <= st_n;
      ack_d_q   <= cpu_ack;
      irq_line  <= glb_en & any;
      vec_valid <= valid_n;
      vec_code  <= code_n;
      dev_ack   <= ack_n;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_ack)); // R5
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (|dev_ack) |=> (dev_ack == '0)); // R5
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_q == GRANT_HELD && cpu_ack) |=> ($stable(vec_code) && vec_valid)); // R6
  AST_LINE_GATED: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq_line); // R3
endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb #(
  parameter int                NUM_DEV  = 8,
  parameter int                CODE_W   = 4,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0C30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic [NUM_DEV-1:0] dev_en,
  input  logic               glb_en,
  input  logic               cpu_ack,
  output logic               irq_line,
  output logic [CODE_W-1:0]  vec_code,
  output logic               vec_valid,
  output logic [ADDR_W-1:0]  isr_addr,
  output logic [NUM_DEV-1:0] dev_ack
);
  logic [NUM_DEV-1:0] pend;
  logic               any;
  logic [CODE_W-1:0]  win;

  assign pend = dev_req & dev_en;

  irq_prio_pick #(.NUM_DEV(NUM_DEV), .CODE_W(CODE_W)) u_pick (
    .pend (pend),
    .any  (any),
    .win  (win)
  );

  irq_grant_hold #(.NUM_DEV(NUM_DEV), .CODE_W(CODE_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .glb_en    (glb_en),
    .any       (any),
    .win       (win),
    .cpu_ack   (cpu_ack),
    .irq_line  (irq_line),
    .vec_valid (vec_valid),
    .vec_code  (vec_code),
    .dev_ack   (dev_ack)
  );

  irq_addr_form #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .VEC_BASE(VEC_BASE)) u_addr (
    .code (vec_code),
    .addr (isr_addr)
  );

  AST_ACK_AT_CODE: assert property (@(posedge clk) disable iff (rst)
    (|dev_ack) |-> ((dev_ack >> vec_code) == NUM_DEV'(1))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pend == '0 && !cpu_ack) |=> (!irq_line && !vec_valid && vec_code == '0)); // R7
endmodule

// File: tb/irq_vector_arb_tb.sv
`timescale 1ns/1ps
module irq_vector_arb_tb;
  localparam int N  = 8;
  localparam int CW = 4;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0C30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] dev_req = '0, dev_en = '0;
  logic glb_en = 1'b0, cpu_ack = 1'b0;
  logic irq_line, vec_valid;
  logic [CW-1:0] vec_code;
  logic [AW-1:0] isr_addr;
  logic [N-1:0] dev_ack;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_vector_arb #(.NUM_DEV(N), .CODE_W(CW), .ADDR_W(AW), .VEC_BASE(BASE)) u_dut (
    .clk(clk), .rst(rst), .dev_req(dev_req), .dev_en(dev_en), .glb_en(glb_en),
    .cpu_ack(cpu_ack), .irq_line(irq_line), .vec_code(vec_code),
    .vec_valid(vec_valid), .isr_addr(isr_addr), .dev_ack(dev_ack)
  );

  // cycle model derived from the requirements
  logic m_line, m_valid, m_lock, m_ackd;
  logic [CW-1:0] m_code;
  logic [N-1:0] m_ack;

  function automatic logic [CW-1:0] lowest(input logic [N-1:0] p);
    logic [CW-1:0] r = '0;
    for (int i = N - 1; i >= 0; i--) if (p[i]) r = CW'(i);
    return r;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [CW-1:0] c);
    return {BASE[AW-1:CW], c};
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] p;
    logic tk, lk;
    p  = dev_req & dev_en;
    tk = cpu_ack && !m_ackd && m_valid;
    lk = cpu_ack && (m_lock || tk);
    if (rst) begin
      m_line <= 0; m_valid <= 0; m_lock <= 0; m_ackd <= 0; m_code <= '0; m_ack <= '0;
    end else begin
      m_line  <= glb_en && (p != '0);
      m_ackd  <= cpu_ack;
      m_lock  <= lk;
      m_ack   <= tk ? (N'(1) << m_code) : '0;
      if (lk) begin
        m_valid <= 1'b1;
      end else if (glb_en && p != '0) begin
        m_valid <= 1'b1; m_code <= lowest(p);
      end else begin
        m_valid <= 1'b0; m_code <= '0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_model(input string req);
    chk(irq_line == m_line, {req, " line"}, 32'(irq_line), 32'(m_line));
    chk(vec_valid == m_valid, {req, " valid"}, 32'(vec_valid), 32'(m_valid));
    chk(vec_code == m_code, {req, " code"}, 32'(vec_code), 32'(m_code));
    chk(dev_ack == m_ack, {req, " ack"}, 32'(dev_ack), 32'(m_ack));
    chk(isr_addr == exp_addr(vec_code), "R4 addr", 32'(isr_addr), 32'(exp_addr(vec_code)));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    // R9 reset state
    chk(!irq_line && !vec_valid && vec_code == '0 && dev_ack == '0, "R9",
        {irq_line, vec_valid, 2'b0, 4'(vec_code), 8'(dev_ack)}, 0);
    chk(isr_addr == BASE, "R9 addr", 32'(isr_addr), 32'(BASE));
    rst = 0; dev_en = '1; glb_en = 1;
    tick();
    chk(!irq_line && !vec_valid && vec_code == '0, "R7 idle", {irq_line, vec_valid}, 0);
    dev_req = 8'b0000_1010;
    tick();
    chk(irq_line, "R1 line", 32'(irq_line), 1);
    chk(vec_valid && vec_code == 4'd1, "R2 lowest wins", 32'(vec_code), 1);
    chk(isr_addr == 16'h0C31, "R4 addr", 32'(isr_addr), 32'h0C31);
    dev_en = 8'b1111_1101;
    tick();
    chk(vec_code == 4'd3, "R8 masked ignored", 32'(vec_code), 3);
    dev_en = '1; cpu_ack = 1;
    tick();
    chk(dev_ack == 8'b0000_1000, "R5 ack pulse", 32'(dev_ack), 32'h08);
    chk(vec_code == 4'd3, "R6 grant held", 32'(vec_code), 3);
    dev_req[3] = 0; dev_req[0] = 1;
    tick();
    chk(dev_ack == '0, "R5 single cycle", 32'(dev_ack), 0);
    chk(vec_code == 4'd3 && vec_valid, "R6 higher prio ignored", 32'(vec_code), 3);
    tick();
    chk(vec_code == 4'd3, "R6 still held", 32'(vec_code), 3);
    cpu_ack = 0;
    tick();
    chk(vec_code == 4'd0, "R10 release", 32'(vec_code), 0);
    glb_en = 0;
    tick();
    chk(!irq_line && !vec_valid, "R3 global off", {irq_line, vec_valid}, 0);
    cpu_ack = 1;
    tick();
    chk(dev_ack == '0, "R5 no pulse when invalid", 32'(dev_ack), 0);
    cpu_ack = 0; glb_en = 1; dev_req = '0;
    tick();

    // random phase against the cycle model
    for (int c = 0; c < 4000; c++) begin
      chk_model("R1 R2 R5 R6 R10 random");
      dev_req = dev_req & ~dev_ack;
      if ($urandom_range(3) == 0) dev_req[$urandom_range(N - 1)] = 1'b1;
      if ($urandom_range(49) == 0) dev_en = N'($urandom);
      glb_en = ($urandom_range(9) != 0);
      if ($urandom_range(3) == 0) cpu_ack = ~cpu_ack;
      tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule